// File: doc/BRIEF.md
# Ripple Comparator Maximum Selector

This combinational block receives two operands and returns whichever one is larger, together with a flag that says whether the first operand won. The decision is made by a chain of identical one-bit cells. A single "strictly greater" signal enters the cell at bit 0 as a constant zero. It then passes upward toward the most significant bit. At each position the signal is either replaced, when the two operand bits differ, or passed on unchanged, when they match. The final value of this signal steers a two-way multiplexer.

A static mode input selects between two readings of the operands. In unsigned mode only the low magnitude bits take part. The flag comes from the last magnitude cell, and the top bit of the result is forced to zero. In signed mode the operands are two's-complement values one bit wider. A further copy of the same cell sits above the chain and handles the sign position. Its two operand inputs are crossed, so a non-negative value beats a negative one. There is no clock and no state. Both outputs depend only on the present inputs.

Top module: `ripple_max_sel`

## Requirements
- R1: In unsigned mode (`mode_signed` = 0), `a_gt_b` is 1 exactly when the low four bits of `opa`, read as an unsigned number, exceed the low four bits of `opb`.
- R2: When the operand bits that take part in the comparison are equal, `a_gt_b` is 0 and `z` carries the `opb` value. For unsigned mode this means `{1'b0, opb[3:0]}`.
- R3: In unsigned mode, `z` equals `{1'b0, opa[3:0]}` when `a_gt_b` is 1 and `{1'b0, opb[3:0]}` otherwise, so `z[4]` is always 0.
- R4: In unsigned mode, bit 4 of `opa` and of `opb` has no effect on `a_gt_b` or on `z`.
- R5: In signed mode (`mode_signed` = 1), `a_gt_b` is 1 exactly when `opa`, read as a five-bit two's-complement number, is strictly greater than `opb` read the same way.
- R6: In signed mode, `z` equals all five bits of `opa` when `a_gt_b` is 1, and all five bits of `opb` otherwise.
- R7: In signed mode, the sign bits (bit 4) override all lower bits. `opa[4]`=0 with `opb[4]`=1 gives `a_gt_b`=1, and `opa[4]`=1 with `opb[4]`=0 gives `a_gt_b`=0.
- R8: The block holds no state. A change on any input appears on the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_signed | input | 1 | 0 selects unsigned comparison of bits 3..0; 1 selects signed comparison of all five bits |
| opa | input | 5 | First operand |
| opb | input | 5 | Second operand |
| a_gt_b | output | 1 | 1 when `opa` is strictly greater than `opb` under the selected mode |
| z | output | 5 | The larger operand; `opb` on a tie |

## Verification
The hardest case to reach is a sign cell that disagrees with the magnitude chain beneath it. An example is a negative `opa` whose low bits are larger than those of a non-negative `opb`. Here the carry arriving at the sign cell is 1, but the crossed inputs must still force the flag to 0. A second hard case is an unsigned run where only the ignored bit 4 differs. The stimulus sweeps every pair of five-bit operands in both modes, so both of these cases occur many times. Each time, the expected flag and result are computed from the language's own signed and unsigned comparisons.

// File: rtl/ripple_max_pkg.sv
package ripple_max_pkg;

    localparam int unsigned MAG_BITS = 4;

    typedef enum logic {
        CMP_UNSIGNED = 1'b0,
        CMP_SIGNED   = 1'b1
    } cmp_mode_e;

    // Removes the sign position when the comparison is unsigned.
    function automatic logic [MAG_BITS:0] narrow_operand(
        input logic [MAG_BITS:0] v,
        input cmp_mode_e         m
    );
        return (m == CMP_SIGNED) ? v : {1'b0, v[MAG_BITS-1:0]};
    endfunction

endpackage

// File: rtl/gt_cell.sv
module gt_cell (
    input  logic x_bit,
    input  logic y_bit,
    input  logic gt_in,
    output logic gt_out
);
    // Majority of (x, ~y, gt_in): differing bits decide, equal bits pass gt_in.
    assign gt_out = (x_bit & ~y_bit) | (x_bit & gt_in) | (~y_bit & gt_in);
endmodule

// File: rtl/gt_chain.sv
module gt_chain #(
    parameter int unsigned MAG_W = 4,
    localparam int unsigned FULL_W = MAG_W + 1
) (
    input  logic [FULL_W-1:0] x_val,
    input  logic [FULL_W-1:0] y_val,
    output logic              gt_mag,
    output logic              gt_sgn
);
    logic [MAG_W:0] ripple;

    assign ripple[0] = 1'b0;

    for (genvar i = 0; i < MAG_W; i++) begin : g_mag
        gt_cell u_cell (
            .x_bit  (x_val[i]),
            .y_bit  (y_val[i]),
            .gt_in  (ripple[i]),
            .gt_out (ripple[i+1])
        );
    end

    // Sign position: same cell, operand inputs crossed.
    gt_cell u_sign_cell (
        .x_bit  (y_val[FULL_W-1]),
        .y_bit  (x_val[FULL_W-1]),
        .gt_in  (ripple[MAG_W]),
        .gt_out (gt_sgn)
    );

    assign gt_mag = ripple[MAG_W];
endmodule

// File: rtl/max_mux.sv
module max_mux #(
    parameter int unsigned W = 5
) (
    input  logic         pick_x,
    input  logic [W-1:0] x_val,
    input  logic [W-1:0] y_val,
    output logic [W-1:0] out_val
);
    always_comb begin
        out_val = pick_x ? x_val : y_val;
    end
endmodule

// File: rtl/ripple_max_sel.sv
module ripple_max_sel
    import ripple_max_pkg::*;
#(
    parameter int unsigned MAG_W = MAG_BITS,
    localparam int unsigned FULL_W = MAG_W + 1
) (
    input  logic              mode_signed,
    input  logic [FULL_W-1:0] opa,
    input  logic [FULL_W-1:0] opb,
    output logic              a_gt_b,
    output logic [FULL_W-1:0] z
);
    cmp_mode_e         mode;
    logic [FULL_W-1:0] opa_eff;
    logic [FULL_W-1:0] opb_eff;
    logic              gt_mag;
    logic              gt_sgn;

    assign mode    = cmp_mode_e'(mode_signed);
    assign opa_eff = (mode == CMP_SIGNED) ? opa : {1'b0, opa[MAG_W-1:0]};
    assign opb_eff = (mode == CMP_SIGNED) ? opb : {1'b0, opb[MAG_W-1:0]};

    gt_chain #(.MAG_W(MAG_W)) u_chain (
        .x_val  (opa),
        .y_val  (opb),
        .gt_mag (gt_mag),
        .gt_sgn (gt_sgn)
    );

    assign a_gt_b = (mode == CMP_SIGNED) ? gt_sgn : gt_mag;

    max_mux #(.W(FULL_W)) u_mux (
        .pick_x  (a_gt_b),
        .x_val   (opa_eff),
        .y_val   (opb_eff),
        .out_val (z)
    );
endmodule

// File: rtl/ripple_max_sel_chk.sv
module ripple_max_sel_chk #(
    parameter int unsigned MAG_W = 4,
    localparam int unsigned FULL_W = MAG_W + 1
) (
    input logic              mode_signed,
    input logic [FULL_W-1:0] opa,
    input logic [FULL_W-1:0] opb,
    input logic              a_gt_b,
    input logic [FULL_W-1:0] z
);
    always_comb begin
        if (!mode_signed) begin
            a_r1_unsigned_flag: assert (a_gt_b == (opa[MAG_W-1:0] > opb[MAG_W-1:0]));
            a_r3_top_bit_zero: assert (z[FULL_W-1] == 1'b0);
            if (opa[MAG_W-1:0] == opb[MAG_W-1:0]) begin
                a_r2_tie_gives_b: assert (!a_gt_b && z == {1'b0, opb[MAG_W-1:0]});
            end
        end else begin
            a_r5_signed_flag: assert (a_gt_b == ($signed(opa) > $signed(opb)));
            a_r6_z_is_operand: assert (z == opa || z == opb);
            if (!opa[FULL_W-1] && opb[FULL_W-1]) begin
                a_r7_pos_beats_neg: assert (a_gt_b);
            end
            if (opa[FULL_W-1] && !opb[FULL_W-1]) begin
                a_r7_neg_loses: assert (!a_gt_b);
            end
        end
    end
endmodule

bind ripple_max_sel ripple_max_sel_chk #(.MAG_W(MAG_W)) u_chk (
    .mode_signed (mode_signed),
    .opa         (opa),
    .opb         (opb),
    .a_gt_b      (a_gt_b),
    .z           (z)
);

// File: tb/ripple_max_sel_test.sv
module ripple_max_sel_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       mode_signed;
    logic [4:0] opa;
    logic [4:0] opb;
    logic       a_gt_b;
    logic [4:0] z;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ripple_max_sel uut (
        .mode_signed (mode_signed),
        .opa         (opa),
        .opb         (opb),
        .a_gt_b      (a_gt_b),
        .z           (z)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s mode=%0d opa=%0d opb=%0d actual=%0d expected=%0d",
                     tag, mode_signed, opa, opb, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic       exp_gt;
        logic [4:0] exp_z;
        string      tag_f;
        string      tag_z;

        mode_signed = 1'b0;
        opa = '0;
        opb = '0;
        @(negedge clk);
        // Initial state: equal zero operands give no win and z = 0 (R2).
        check("R2", a_gt_b, 0);
        check("R2", z, 0);

        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 32; a++) begin
                for (int b = 0; b < 32; b++) begin
                    @(posedge clk);
                    mode_signed = m[0];
                    opa = a[4:0];
                    opb = b[4:0];
                    @(negedge clk);
                    if (m == 0) begin
                        exp_gt = (a[3:0] > b[3:0]);
                        exp_z  = exp_gt ? {1'b0, a[3:0]} : {1'b0, b[3:0]};
                        if (a[3:0] == b[3:0])  tag_f = "R2";
                        else if (a[4] | b[4])  tag_f = "R4";
                        else                   tag_f = "R1";
                        tag_z = (a[4] | b[4]) ? "R4" : "R3";
                    end else begin
                        exp_gt = ($signed(a[4:0]) > $signed(b[4:0]));
                        exp_z  = exp_gt ? a[4:0] : b[4:0];
                        if (a[4] != b[4])      tag_f = "R7";
                        else if (a == b)       tag_f = "R2";
                        else                   tag_f = "R5";
                        tag_z = "R6";
                    end
                    check(tag_f, a_gt_b, exp_gt);
                    check(tag_z, z, exp_z);
                end
            end
        end

        // R8: outputs follow inputs with no clock edge in between.
        @(negedge clk);
        mode_signed = 1'b1;
        opa = 5'b00011;
        opb = 5'b11111;
        #1;
        check("R8", a_gt_b, 1);
        check("R8", z, 5'b00011);
        opa = 5'b10000;
        #1;
        check("R8", a_gt_b, 0);
        check("R8", z, 5'b11111);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule